// File: doc/BRIEF.md
# Phase Build-Out Hitless Switch

This block sits in front of a digital loop's phase detector and hides phase steps in the reference from the loop. It runs on a fast sampling clock and receives one-cycle event pulses for the reference edge and for the feedback edge. From these it produces a virtual reference pulse and a signed phase offset, both counted in sampling-clock cycles. The reference period is a fixed number of cycles, set by a parameter. A free-running phase counter restarts at every reference pulse and wraps at that period.

Every feedback pulse measures where the feedback edge falls within the reference period. The result is kept as a signed offset on the shortest path around the period. When build-out is engaged, the latest measurement is latched as the build-out offset. The virtual reference is then regenerated late by that offset, so it lines up with the feedback edge the loop already follows. A reference switch therefore causes no output phase step. Build-out can be engaged by an external pin or by the automatic logic of a mode controller.

When build-out is released, the offset is walked back toward zero on a frame tick, by at most a fixed step per tick. The output then slides into true alignment at a bounded slope. A low level on the clear input zeroes the offset, but only after it has been held for a minimum width. Both time limits are parameters given in nanoseconds and converted to whole sampling-clock cycles.

Top module: `pboHitless`

## Requirements
- R1: After reset, `virtRef` is low and `phaseOffset` is zero.
- R2: A cycle with `refPulse` high has phase 0, and each following cycle adds one, wrapping at `REF_PERIOD`. A cycle with `fbPulse` high at phase p records p as the measured offset when p < REF_PERIOD/2, and p − REF_PERIOD otherwise. The measurement is two's complement, `PW` bits wide.
- R3: On the first cycle the enable (pin OR auto) is high after being low, `phaseOffset` takes the most recent measured offset at the next clock edge. It then holds that value while the enable stays high, even when new measurements arrive.
- R4: Either `tieEnPin` or `tieEnAuto` alone engages build-out.
- R5: `virtRef` is high for the cycle after each cycle whose phase equals `phaseOffset` taken modulo `REF_PERIOD`. With offset 0, it follows each reference pulse by one cycle.
- R6: When `clrN` has been sampled low on CLR_CYC = ceil(CLR_NS/CLK_NS) consecutive edges, `phaseOffset` becomes zero at that edge. This takes priority over loading.
- R7: A low pulse on `clrN` shorter than CLR_CYC cycles leaves `phaseOffset` unchanged.
- R8: While the enable is low, each cycle with `frameTick` high moves `phaseOffset` toward zero by min(|offset|, SLEW_CYC). Here SLEW_CYC = max(1, floor(SLEW_NS/CLK_NS)). Without a tick, or while the enable is high, a tick leaves the offset unchanged.
- R9: A negative offset slews upward toward zero, which is the shorter way around the period, and stops exactly at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | One-cycle reference edge event |
| fbPulse | input | 1 | One-cycle feedback edge event |
| tieEnPin | input | 1 | Build-out enable from the external pin |
| tieEnAuto | input | 1 | Build-out enable from the mode controller |
| clrN | input | 1 | Active-low clear of the stored offset, width-filtered |
| frameTick | input | 1 | One-cycle frame tick pacing the slew |
| virtRef | output | 1 | Virtual reference pulse toward the loop |
| phaseOffset | output | PW | Signed build-out offset in sampling cycles |

## Verification
The bench builds the block with a 64-cycle reference period and a 2 ns sampling period. With these values the clear filter needs 150 low cycles and the slew step is 2 cycles per tick. This makes a 149-cycle near-miss clear pulse easy to drive, and it makes a step larger than one visible, so clamping at zero is exercised. A feedback phase of 40 produces the negative measurement −24, which covers the wrap and the upward slew. A 20-cycle jump in reference phase while engaged shows the virtual reference staying where the loop expects it.

// File: rtl/pboPkg.sv
package pboPkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;   // latch measured offset into build-out register
    logic clear;  // zero the build-out register
    logic slew;   // step build-out register toward zero
  } pboStb_t;
endpackage

// File: rtl/pboClrFilter.sv
module pboClrFilter #(
  parameter int CLR_CYC = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic clrN,
  output logic clrHit
);
  localparam int CNT_W = $clog2(CLR_CYC + 1);

  logic [CNT_W-1:0] lowCnt;

  // fires once, on the CLR_CYC-th consecutive low sample
  assign clrHit = !clrN && (lowCnt == CNT_W'(CLR_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (clrN) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_W'(CLR_CYC)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pboCtrl.sv
module pboCtrl
  import pboPkg::*;
#(
  parameter int CLR_CYC = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tieEnPin,
  input  logic    tieEnAuto,
  input  logic    clrN,
  input  logic    frameTick,
  output pboStb_t stb,
  output logic    enLvl
);
  logic enPrev;
  logic clrHit;

  assign enLvl = tieEnPin | tieEnAuto;

  pboClrFilter #(.CLR_CYC(CLR_CYC)) u_clrFilter (
    .clk   (clk),
    .rstN  (rstN),
    .clrN  (clrN),
    .clrHit(clrHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enLvl;
  end

  always_comb begin
    stb.clear = clrHit;
    stb.load  = enLvl & ~enPrev;
    stb.slew  = frameTick & ~enLvl;
  end
endmodule

// File: rtl/pboDatapath.sv
module pboDatapath
  import pboPkg::*;
#(
  parameter int REF_PERIOD = 64,
  parameter int SLEW_CYC   = 1,
  localparam int CW        = $clog2(REF_PERIOD),
  localparam int PW        = CW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refPulse,
  input  logic          fbPulse,
  input  pboStb_t       stb,
  output logic          virtRef,
  output logic [PW-1:0] buildOut
);
  localparam int HALF = REF_PERIOD / 2;

  logic [CW-1:0] sinceRef;
  logic [CW-1:0] curPhase;
  logic [PW-1:0] measOff;
  logic [PW-1:0] phSigned;
  logic [PW-1:0] wrapSum;
  logic [CW-1:0] appliedU;
  logic [PW-1:0] absVal;
  logic [PW-1:0] stepVal;
  logic [PW-1:0] slewNext;

  // phase of the current cycle relative to the last reference event
  assign curPhase = refPulse ? '0 : sinceRef;

  // fold the phase onto the signed shortest-path range
  assign phSigned = {1'b0, curPhase}
                  - ((int'(curPhase) >= HALF) ? PW'(REF_PERIOD) : PW'(0));

  // signed offset mapped back to a phase position
  assign wrapSum  = buildOut + PW'(REF_PERIOD);
  assign appliedU = buildOut[PW-1] ? wrapSum[CW-1:0] : buildOut[CW-1:0];

  // one rate-limited step toward zero
  assign absVal   = buildOut[PW-1] ? (~buildOut + 1'b1) : buildOut;
  assign stepVal  = (absVal > PW'(SLEW_CYC)) ? PW'(SLEW_CYC) : absVal;
  assign slewNext = buildOut[PW-1] ? (buildOut + stepVal) : (buildOut - stepVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRef <= '0;
    end else if (int'(curPhase) == REF_PERIOD - 1) begin
      sinceRef <= '0;
    end else begin
      sinceRef <= curPhase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        measOff <= '0;
    else if (fbPulse) measOff <= phSigned;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          buildOut <= '0;
    else if (stb.clear) buildOut <= '0;
    else if (stb.load)  buildOut <= measOff;
    else if (stb.slew)  buildOut <= slewNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) virtRef <= 1'b0;
    else       virtRef <= (curPhase == appliedU);
  end
endmodule

// File: rtl/pboHitless.sv
module pboHitless
  import pboPkg::*;
#(
  parameter int REF_PERIOD = 64,
  parameter int CLK_NS     = 20,
  parameter int CLR_NS     = 300,
  parameter int SLEW_NS    = 5,
  localparam int PW        = $clog2(REF_PERIOD) + 1,
  localparam int CLR_CYC   = (CLR_NS + CLK_NS - 1) / CLK_NS,
  localparam int SLEW_CYC  = (SLEW_NS / CLK_NS < 1) ? 1 : SLEW_NS / CLK_NS
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refPulse,
  input  logic          fbPulse,
  input  logic          tieEnPin,
  input  logic          tieEnAuto,
  input  logic          clrN,
  input  logic          frameTick,
  output logic          virtRef,
  output logic [PW-1:0] phaseOffset
);
  pboStb_t ctrlStb;
  logic    enLvl;

  pboCtrl #(.CLR_CYC(CLR_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tieEnPin (tieEnPin),
    .tieEnAuto(tieEnAuto),
    .clrN     (clrN),
    .frameTick(frameTick),
    .stb      (ctrlStb),
    .enLvl    (enLvl)
  );

  pboDatapath #(.REF_PERIOD(REF_PERIOD), .SLEW_CYC(SLEW_CYC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refPulse(refPulse),
    .fbPulse (fbPulse),
    .stb     (ctrlStb),
    .virtRef (virtRef),
    .buildOut(phaseOffset)
  );
endmodule

// File: rtl/pboHitlessChk.sv
module pboHitlessChk
  import pboPkg::*;
#(
  parameter int PW       = 7,
  parameter int SLEW_CYC = 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          clrN,
  input logic          frameTick,
  input logic          enLvl,
  input pboStb_t       stb,
  input logic [PW-1:0] phaseOffset
);
  // R3
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enLvl && !stb.load && !stb.clear) |=> $stable(phaseOffset));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (phaseOffset == '0));

  // R7
  clear_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |-> (!clrN && $past(!clrN)));

  // R8
  slew_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.clear) |=>
      ((int'($signed(phaseOffset)) - int'($signed($past(phaseOffset))) <= SLEW_CYC) &&
       (int'($signed(phaseOffset)) - int'($signed($past(phaseOffset))) >= -SLEW_CYC)));

  // R8
  no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && !enLvl && !stb.clear) |=> $stable(phaseOffset));
endmodule

bind pboHitless pboHitlessChk #(.PW(PW), .SLEW_CYC(SLEW_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clrN       (clrN),
  .frameTick  (frameTick),
  .enLvl      (enLvl),
  .stb        (ctrlStb),
  .phaseOffset(phaseOffset)
);

// File: tb/pboHitless_bench.sv
module pboHitless_bench;
  localparam int P       = 64;
  localparam int CLKNS   = 2;
  localparam int CLR     = 150;   // ceil(300/2)
  localparam int SLEW    = 2;     // floor(5/2)
  localparam int PWB     = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0, fbPulse = 1'b0;
  logic tieEnPin = 1'b0, tieEnAuto = 1'b0;
  logic clrN = 1'b1, frameTick = 1'b0;
  logic virtRef;
  logic [PWB-1:0] phaseOffset;

  int checks = 0;
  int fails = 0;
  string curReq = "R5";

  // stimulus generator state
  int genPos = 0;
  int fbPhase = 10;
  int jumpAmt = 0;
  int jumpSeq = 0;
  int lastSeq = 0;

  // model state
  int mSince = 0, mMeas = 0, mBuild = 0, mLow = 0;
  bit mEnPrev = 0, mVirt = 0;

  always #10 clk = ~clk;

  pboHitless #(.REF_PERIOD(P), .CLK_NS(CLKNS), .CLR_NS(300), .SLEW_NS(5)) u_pboHitless (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .tieEnPin(tieEnPin), .tieEnAuto(tieEnAuto), .clrN(clrN),
    .frameTick(frameTick), .virtRef(virtRef), .phaseOffset(phaseOffset)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference and feedback event generator
  always @(negedge clk) begin
    if (jumpSeq != lastSeq) begin
      lastSeq = jumpSeq;
      genPos = (genPos + jumpAmt) % P;
    end
    refPulse <= (genPos == 0);
    fbPulse  <= (genPos == fbPhase);
    genPos = (genPos + 1) % P;
  end

  // behavioural reference model
  always @(posedge clk) begin
    int p, au, nb, mag;
    bit fire, en;
    if (!rstN) begin
      mSince = 0; mMeas = 0; mBuild = 0; mLow = 0; mEnPrev = 0; mVirt = 0;
    end else begin
      p = refPulse ? 0 : mSince;
      mLow = clrN ? 0 : mLow + 1;
      fire = (mLow == CLR);
      en = tieEnPin || tieEnAuto;
      au = (mBuild < 0) ? mBuild + P : mBuild;
      nb = mBuild;
      if (fire) nb = 0;
      else if (en && !mEnPrev) nb = mMeas;
      else if (!en && frameTick) begin
        mag = (mBuild < 0) ? -mBuild : mBuild;
        if (mag > SLEW) mag = SLEW;
        nb = (mBuild < 0) ? mBuild + mag : mBuild - mag;
      end
      if (fbPulse) mMeas = (p >= P / 2) ? p - P : p;
      mVirt = (p == au);
      mSince = (p + 1) % P;
      mEnPrev = en;
      mBuild = nb;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk({curReq, " virtRef"}, int'(virtRef), int'(mVirt));
      chk({curReq, " phaseOffset"}, int'($signed(phaseOffset)), mBuild);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      frameTick = 1'b1; cyc(1);
      frameTick = 1'b0; cyc(9);
    end
  endtask

  initial begin
    cyc(5);
    // R1
    chk("R1 virtRef", int'(virtRef), 0);
    chk("R1 phaseOffset", int'($signed(phaseOffset)), 0);
    rstN = 1'b1;
    curReq = "R5";
    cyc(200);
    // R2 R4: pin alone engages, loads +10
    curReq = "R3";
    tieEnPin = 1'b1; cyc(3);
    chk("R2 positive measurement via R4 pin", int'($signed(phaseOffset)), 10);
    // R3: new measurement does not disturb held offset
    fbPhase = 40; cyc(200);
    chk("R3 hold while enabled", int'($signed(phaseOffset)), 10);
    // R8: tick while enabled ignored
    ticks(3);
    chk("R8 tick ignored while enabled", int'($signed(phaseOffset)), 10);
    // R5: reference switch, virtual reference keeps the loop's phase
    curReq = "R5";
    jumpAmt = 20; jumpSeq++;
    cyc(300);
    // R8: disable, no tick means no change
    curReq = "R8";
    tieEnPin = 1'b0; cyc(100);
    chk("R8 no tick no change", int'($signed(phaseOffset)), 10);
    ticks(3);
    chk("R8 three steps", int'($signed(phaseOffset)), 4);
    ticks(4);
    chk("R8 clamps at zero", int'($signed(phaseOffset)), 0);
    // R4: auto alone engages, negative measurement
    curReq = "R4";
    tieEnAuto = 1'b1; cyc(3);
    chk("R4 auto loads wrapped R2 measurement", int'($signed(phaseOffset)), -24);
    cyc(150);
    // R7: near-miss clear pulse
    curReq = "R7";
    clrN = 1'b0; cyc(CLR - 1); clrN = 1'b1; cyc(5);
    chk("R7 short clear ignored", int'($signed(phaseOffset)), -24);
    // R6: full width clear
    curReq = "R6";
    clrN = 1'b0; cyc(CLR); cyc(1);
    chk("R6 clear at full width", int'($signed(phaseOffset)), 0);
    cyc(100); clrN = 1'b1; cyc(5);
    chk("R6 stays clear", int'($signed(phaseOffset)), 0);
    // R9: negative slew upward
    curReq = "R9";
    tieEnAuto = 1'b0; cyc(5);
    tieEnPin = 1'b1; cyc(3);
    chk("R9 reload", int'($signed(phaseOffset)), -24);
    tieEnPin = 1'b0; cyc(5);
    ticks(5);
    chk("R9 upward slew", int'($signed(phaseOffset)), -14);
    ticks(8);
    chk("R9 stops at zero", int'($signed(phaseOffset)), 0);
    curReq = "R5";
    cyc(200);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule